// File: doc/BRIEF.md
# Bonded Write Command and Acknowledge Combiner

This block joins one wide master port to two memory controllers that run as a bonded pair. Every command from the master goes to both controllers in the same cycle, with the same address and the same read/write flag. The write data word is cut in two: the low slice goes to controller A and the remaining upper bits go to controller B. The slice widths follow the data widths of the two controllers. No address decides where a command goes.

The two controller ready inputs are merged into one stall output. A command is handed to the controllers only in a cycle where both are ready, so neither controller can take a command that the other has not taken. The two controllers run without any synchronization between them, so their in-order write completions can arrive at different times. One side may lead the other by several completions. A pending counter on each side records completions that have not yet been paired. Whenever both counters hold a completion, the master receives one acknowledge pulse and both counters drop by one.

Top module: `bond_wr_combiner`

## Requirements
- R1: `a_addr`/`b_addr` always equal `m_addr`, and `a_write`/`b_write` always equal `m_write`. Both sides always receive the same command.
- R2: `a_wdata` always equals `m_wdata[LO_W-1:0]`, and `b_wdata` always equals `m_wdata[LO_W+HI_W-1:LO_W]`.
- R3: `a_valid` and `b_valid` are both 1 exactly in cycles where `m_valid`, `a_ready` and `b_ready` are all 1. In every other cycle both are 0. A side is never issued a command alone.
- R4: `m_stall` is 1 exactly when `m_valid` is 1 and at least one of `a_ready`/`b_ready` is 0. While `m_valid` is 0, `m_stall` is 0 and no command is issued.
- R5: At each clock edge, a side's pending counter is incremented when that side's ack input is 1. It is decremented when `m_ack` is 1 in that cycle.
- R6: `m_ack` is 1, for one cycle per pair, exactly while both pending counters are nonzero. With simultaneous side acks, `m_ack` rises in the cycle after the edge that sampled them.
- R7: Skew is absorbed. If N acks arrive on one side before any arrive on the other, `m_ack` stays 0 until the other side delivers. The total number of `m_ack` pulses then equals the number of matched pairs.
- R8: A pending counter never underflows, and the number of `m_ack` pulses never exceeds the number of write commands accepted by both controllers.
- R9: After reset both pending counters are zero and `m_ack` is 0.
- R10: The widths are checked at elaboration: `LO_W+HI_W` lies in 64..256, and each side is at least 8 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_valid | input | 1 | Master command valid |
| m_write | input | 1 | Master command is a write |
| m_addr | input | ADDR_W | Master command address |
| m_wdata | input | LO_W+HI_W | Master write data |
| m_stall | output | 1 | Bonded stall to master |
| m_ack | output | 1 | Bonded write acknowledge |
| a_valid | output | 1 | Command valid to controller A |
| a_write | output | 1 | Write flag to controller A |
| a_addr | output | ADDR_W | Address to controller A |
| a_wdata | output | LO_W | Write data slice to controller A |
| a_ready | input | 1 | Controller A can accept |
| a_ack | input | 1 | Controller A write completion |
| b_valid | output | 1 | Command valid to controller B |
| b_write | output | 1 | Write flag to controller B |
| b_addr | output | ADDR_W | Address to controller B |
| b_wdata | output | HI_W | Write data slice to controller B |
| b_ready | input | 1 | Controller B can accept |
| b_ack | input | 1 | Controller B write completion |

## Verification
A wrong pending counter appears at `m_ack`, and no later than one cycle after the pairing decision goes wrong. A lost side ack drops an acknowledge once the other side delivers. A spurious increment produces an extra pulse as soon as the opposite counter becomes nonzero. A fault in the issue gating appears combinationally in the same cycle: a side valid is raised while its partner is not ready, or the stall and the issue disagree. The bench drives long skewed ack runs and keeps a shadow pairing model, so counter faults are caught within the window of the skew.

// File: rtl/bond_pkg.sv
package bond_pkg;
   typedef enum logic [0:0] {
      SIDE_A = 1'b0,
      SIDE_B = 1'b1
   } bond_side_e;

   localparam int unsigned BOND_SIDES    = 2;
   localparam int unsigned BOND_MIN_DW   = 64;
   localparam int unsigned BOND_MAX_DW   = 256;
   localparam int unsigned BOND_MIN_SIDE = 8;

   function automatic logic width_ok(input int unsigned lo_w, input int unsigned hi_w);
      return (lo_w + hi_w >= BOND_MIN_DW) && (lo_w + hi_w <= BOND_MAX_DW)
             && (lo_w >= BOND_MIN_SIDE) && (hi_w >= BOND_MIN_SIDE);
   endfunction
endpackage

// File: rtl/bond_cmd_gate.sv
module bond_cmd_gate #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned LO_W   = 24,
   parameter int unsigned HI_W   = 40,
   localparam int unsigned DW    = LO_W + HI_W
) (
   input  logic              m_valid,
   input  logic              m_write,
   input  logic [ADDR_W-1:0] m_addr,
   input  logic [DW-1:0]     m_wdata,
   output logic              m_stall,
   output logic              issue,
   output logic              a_valid,
   output logic              a_write,
   output logic [ADDR_W-1:0] a_addr,
   output logic [LO_W-1:0]   a_wdata,
   input  logic              a_ready,
   output logic              b_valid,
   output logic              b_write,
   output logic [ADDR_W-1:0] b_addr,
   output logic [HI_W-1:0]   b_wdata,
   input  logic              b_ready
);
   logic both_ready;

   always_comb begin
      both_ready = a_ready & b_ready;
      issue      = m_valid & both_ready;
      m_stall    = m_valid & ~both_ready;
   end

   // Command fields fan out to both sides unchanged.
   always_comb begin
      a_valid = issue;
      b_valid = issue;
      a_write = m_write;
      b_write = m_write;
      a_addr  = m_addr;
      b_addr  = m_addr;
   end

   // Data slices follow the controller widths: low part to A, upper part to B.
   always_comb begin
      a_wdata = m_wdata[LO_W-1:0];
      b_wdata = m_wdata[DW-1:LO_W];
   end
endmodule

// File: rtl/bond_ack_cnt.sv
module bond_ack_cnt #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             dec,
   output logic [CNT_W-1:0] cnt,
   output logic             nz
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         unique case ({inc, dec})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   always_comb begin
      cnt = cnt_q;
      nz  = |cnt_q;
   end
endmodule

// File: rtl/bond_ack_pair.sv
module bond_ack_pair #(
   parameter int unsigned CNT_W    = 4,
   parameter bit          FAST_ACK = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             a_ack,
   input  logic             b_ack,
   output logic             m_ack,
   output logic [CNT_W-1:0] cnt_a,
   output logic [CNT_W-1:0] cnt_b
);
   import bond_pkg::*;

   logic [BOND_SIDES-1:0] side_ack;
   logic [BOND_SIDES-1:0] side_nz;
   logic [BOND_SIDES-1:0] side_avail;
   logic [CNT_W-1:0]      side_cnt [BOND_SIDES];
   logic                  pop;

   always_comb begin
      side_ack[SIDE_A] = a_ack;
      side_ack[SIDE_B] = b_ack;
   end

   for (genvar s = 0; s < BOND_SIDES; s++) begin : g_side
      bond_ack_cnt #(.CNT_W(CNT_W)) cnt_i (
         .clk  (clk),
         .rst_n(rst_n),
         .inc  (side_ack[s]),
         .dec  (pop),
         .cnt  (side_cnt[s]),
         .nz   (side_nz[s])
      );
      if (FAST_ACK) begin : g_fast
         assign side_avail[s] = side_nz[s] | side_ack[s];
      end else begin : g_reg
         assign side_avail[s] = side_nz[s];
      end
   end

   always_comb begin
      pop   = &side_avail;
      m_ack = pop;
      cnt_a = side_cnt[SIDE_A];
      cnt_b = side_cnt[SIDE_B];
   end
endmodule

// File: rtl/bond_wr_combiner.sv
module bond_wr_combiner #(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned LO_W     = 24,
   parameter int unsigned HI_W     = 40,
   parameter int unsigned CNT_W    = 4,
   parameter bit          FAST_ACK = 1'b0,
   localparam int unsigned DW      = LO_W + HI_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              m_valid,
   input  logic              m_write,
   input  logic [ADDR_W-1:0] m_addr,
   input  logic [DW-1:0]     m_wdata,
   output logic              m_stall,
   output logic              m_ack,
   output logic              a_valid,
   output logic              a_write,
   output logic [ADDR_W-1:0] a_addr,
   output logic [LO_W-1:0]   a_wdata,
   input  logic              a_ready,
   input  logic              a_ack,
   output logic              b_valid,
   output logic              b_write,
   output logic [ADDR_W-1:0] b_addr,
   output logic [HI_W-1:0]   b_wdata,
   input  logic              b_ready,
   input  logic              b_ack
);
   import bond_pkg::*;

   // R10: elaboration-time width checks
   if (!width_ok(LO_W, HI_W)) begin : g_bad_width
      $error("bond_wr_combiner: side widths out of range");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("bond_wr_combiner: CNT_W too small");
   end

   logic             issue;
   logic [CNT_W-1:0] cnt_a;
   logic [CNT_W-1:0] cnt_b;

   bond_cmd_gate #(
      .ADDR_W(ADDR_W),
      .LO_W  (LO_W),
      .HI_W  (HI_W)
   ) gate_i (
      .m_valid(m_valid),
      .m_write(m_write),
      .m_addr (m_addr),
      .m_wdata(m_wdata),
      .m_stall(m_stall),
      .issue  (issue),
      .a_valid(a_valid),
      .a_write(a_write),
      .a_addr (a_addr),
      .a_wdata(a_wdata),
      .a_ready(a_ready),
      .b_valid(b_valid),
      .b_write(b_write),
      .b_addr (b_addr),
      .b_wdata(b_wdata),
      .b_ready(b_ready)
   );

   bond_ack_pair #(
      .CNT_W   (CNT_W),
      .FAST_ACK(FAST_ACK)
   ) pair_i (
      .clk  (clk),
      .rst_n(rst_n),
      .a_ack(a_ack),
      .b_ack(b_ack),
      .m_ack(m_ack),
      .cnt_a(cnt_a),
      .cnt_b(cnt_b)
   );

   logic unused_ok;
   always_comb unused_ok = issue ^ (|cnt_a) ^ (|cnt_b);
endmodule

// File: rtl/bond_wr_combiner_chk.sv
module bond_wr_combiner_chk #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned LO_W   = 24,
   parameter int unsigned HI_W   = 40,
   localparam int unsigned DW    = LO_W + HI_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              m_valid,
   input logic              m_write,
   input logic [ADDR_W-1:0] m_addr,
   input logic [DW-1:0]     m_wdata,
   input logic              m_stall,
   input logic              m_ack,
   input logic              a_valid,
   input logic              a_ready,
   input logic              a_ack,
   input logic              b_valid,
   input logic              b_ready,
   input logic              b_ack
);
   logic [15:0] pend_a, pend_b, outst;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_a <= '0;
         pend_b <= '0;
         outst  <= '0;
      end else begin
         pend_a <= pend_a + 16'(a_ack) - 16'(m_ack);
         pend_b <= pend_b + 16'(b_ack) - 16'(m_ack);
         outst  <= outst + 16'(a_valid & a_ready & m_write) - 16'(m_ack);
      end
   end

   // R3: a side is never issued a command while its partner is not ready
   a_r3_pair_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (a_valid || b_valid) |-> (a_ready && b_ready && a_valid && b_valid));

   // R4: stall and issue are mutually exclusive
   a_r4_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      m_stall |-> (!a_valid && !b_valid));

   // R4: a valid master with both ready is never stalled
   a_r4_no_false_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && a_ready && b_ready) |-> (!m_stall && a_valid));

   // R8: pairing never pops a side that has no completion
   a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      m_ack |-> ((pend_a + 16'(a_ack)) != 0 && (pend_b + 16'(b_ack)) != 0));

   // R8: acknowledges never outnumber accepted writes
   a_r8_ack_bound: assert property (@(posedge clk) disable iff (!rst_n)
      m_ack |-> (outst != 0));

   logic unused_chk;
   always_comb unused_chk = ^m_addr ^ ^m_wdata;
endmodule

bind bond_wr_combiner bond_wr_combiner_chk #(
   .ADDR_W(ADDR_W),
   .LO_W  (LO_W),
   .HI_W  (HI_W)
) chk_i (
   .clk    (clk),
   .rst_n  (rst_n),
   .m_valid(m_valid),
   .m_write(m_write),
   .m_addr (m_addr),
   .m_wdata(m_wdata),
   .m_stall(m_stall),
   .m_ack  (m_ack),
   .a_valid(a_valid),
   .a_ready(a_ready),
   .a_ack  (a_ack),
   .b_valid(b_valid),
   .b_ready(b_ready),
   .b_ack  (b_ack)
);

// File: tb/bond_wr_combiner_tb.sv
module bond_wr_combiner_tb_top;
   localparam int unsigned ADDR_W = 32;
   localparam int unsigned LO_W   = 24;
   localparam int unsigned HI_W   = 40;
   localparam int unsigned DW     = LO_W + HI_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_valid = 0, m_write = 0;
   logic [ADDR_W-1:0] m_addr = '0;
   logic [DW-1:0] m_wdata = '0;
   logic m_stall, m_ack;
   logic a_valid, a_write, b_valid, b_write;
   logic [ADDR_W-1:0] a_addr, b_addr;
   logic [LO_W-1:0] a_wdata;
   logic [HI_W-1:0] b_wdata;
   logic a_ready = 0, b_ready = 0, a_ack = 0, b_ack = 0;

   int total = 0;
   int bad = 0;
   int ca = 0, cb = 0, pa = 0, pb = 0, ow = 0, acks_seen = 0;

   always #5 clk = ~clk;

   bond_wr_combiner #(.ADDR_W(ADDR_W), .LO_W(LO_W), .HI_W(HI_W)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .m_valid(m_valid), .m_write(m_write), .m_addr(m_addr), .m_wdata(m_wdata),
      .m_stall(m_stall), .m_ack(m_ack),
      .a_valid(a_valid), .a_write(a_write), .a_addr(a_addr), .a_wdata(a_wdata),
      .a_ready(a_ready), .a_ack(a_ack),
      .b_valid(b_valid), .b_write(b_write), .b_addr(b_addr), .b_wdata(b_wdata),
      .b_ready(b_ready), .b_ack(b_ack)
   );

   function automatic logic exp_issue(input logic v, input logic ar, input logic br);
      return v & ar & br;
   endfunction

   function automatic logic exp_stall(input logic v, input logic ar, input logic br);
      return v & ~(ar & br);
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // Check all outputs against the model, then advance the model to the next edge.
   task automatic step_check();
      logic ei, ea;
      #1;
      ei = exp_issue(m_valid, a_ready, b_ready);
      ea = (ca > 0) && (cb > 0);
      check(a_valid == ei && b_valid == ei, "R3 issue", {a_valid, b_valid}, {ei, ei});
      check(m_stall == exp_stall(m_valid, a_ready, b_ready), "R4 stall", m_stall,
            exp_stall(m_valid, a_ready, b_ready));
      check(a_addr == m_addr && b_addr == m_addr && a_write == m_write && b_write == m_write,
            "R1 fanout", {a_addr, b_addr}, {m_addr, m_addr});
      check(a_wdata == m_wdata[LO_W-1:0], "R2 low slice", 64'(a_wdata), 64'(m_wdata[LO_W-1:0]));
      check(b_wdata == m_wdata[DW-1:LO_W], "R2 high slice", 64'(b_wdata), 64'(m_wdata[DW-1:LO_W]));
      check(m_ack == ea, "R6 ack", m_ack, ea);
      if (m_ack) acks_seen++;
      if (ei && m_write) begin pa++; pb++; ow++; end
      if (a_ack) begin pa--; ca++; end
      if (b_ack) begin pb--; cb++; end
      if (ea) begin ca--; cb--; ow--; end
   endtask

   task automatic idle_drive();
      m_valid = 0; m_write = 0; a_ack = 0; b_ack = 0;
   endtask

   initial begin
      #(10 * 150000);
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      #1;
      // R9: reset state
      check(m_ack == 1'b0, "R9 reset ack", m_ack, 0);
      check(a_valid == 0 && b_valid == 0, "R9 reset issue", {a_valid, b_valid}, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // Directed: R4 idle, no stall
      idle_drive(); a_ready = 1; b_ready = 0;
      step_check();
      check(m_stall == 0, "R4 idle no stall", m_stall, 0);

      // Directed: R3 one side ready only
      @(negedge clk);
      m_valid = 1; m_write = 1; m_addr = 32'h1000; m_wdata = 64'h0123_4567_89ab_cdef;
      a_ready = 1; b_ready = 0;
      step_check();
      @(negedge clk);
      a_ready = 0; b_ready = 1;
      step_check();
      // Three writes accepted
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         a_ready = 1; b_ready = 1; m_addr = 32'h2000 + i;
         step_check();
      end
      @(negedge clk); idle_drive(); step_check();

      // Directed: R7 skew, A leads by three
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); a_ack = 1; b_ack = 0;
         step_check();
      end
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); a_ack = 0; b_ack = 0;
         step_check();
         check(m_ack == 0, "R7 no ack while B silent", m_ack, 0);
      end
      acks_seen = 0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); a_ack = 0; b_ack = 1;
         step_check();
      end
      for (int i = 0; i < 4; i++) begin
         @(negedge clk); idle_drive();
         step_check();
      end
      check(acks_seen == 3, "R7 pair count", acks_seen, 3);
      check(ca == 0 && cb == 0, "R5 drained", {ca, cb}, 0);

      // Constrained random
      for (int cyc = 0; cyc < 4000; cyc++) begin
         @(negedge clk);
         m_valid = ($urandom % 4) != 0;
         m_write = (ow < 10) ? ($urandom % 2) : 1'b0;
         m_addr  = $urandom;
         m_wdata = {$urandom, $urandom};
         a_ready = ($urandom % 3) != 0;
         b_ready = ($urandom % 3) != 0;
         a_ack   = (pa > 0) && (($urandom % ((cyc / 500) % 2 == 0 ? 3 : 7)) == 0);
         b_ack   = (pb > 0) && (($urandom % 4) == 0);
         step_check();
      end

      // Drain: deliver all outstanding side acks
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         m_valid = 0; m_write = 0;
         a_ack = pa > 0; b_ack = pb > 0;
         step_check();
      end
      check(ow == 0 && ca == 0 && cb == 0, "R8 all writes acknowledged once", ow, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule